// File: doc/BRIEF.md
# Single-Bus Microcoded Datapath

This block is the data side of a small 32-bit processor whose control comes from an external microprogram. Every storage element and every functional unit connects to one shared 32-bit bus. Each cycle the microcode picks one source to drive the bus and any number of destinations to capture it. One micro-step is therefore exactly one register transfer. The program counter is an extra entry in the register file, and the link register is selected directly, so fetch, jump-and-link and branch sequences need no special paths.

The sequencer reads back three status values: the opcode field of the instruction register, a flag that is set when the A latch is zero, and the memory stall flag. Memory sits outside the block and is reached through a plain port. The address comes from the memory address register, write data is the bus value, a read strobe accompanies a memory drive of the bus, and a stall input holds the sequencer while an access is pending.

Top module: `sbus_datapath`

## Requirements
- R1: After reset the register file (including the PC entry), IR, A, B and MA are all zero, so `opcode` is 0, `zero` is 1 and `mem_addr` is 0.
- R2: At most one of `drv_rf`, `drv_ext`, `drv_alu`, `drv_mem` is set in a cycle. The bus, visible on `mem_wdata`, then carries that source's value: the selected register, the extender output, the ALU result, or `mem_rdata`.
- R3: `cap_ir`, `cap_a`, `cap_b` and `cap_ma` each load the bus value at the rising edge. A latch whose capture input is low keeps its value.
- R4: `rf_sel` chooses the register index: 0 = IR[25:21], 1 = IR[20:16], 2 = IR[15:11], 3 = register 31, 4 = the PC entry. Codes 5 to 7 select register 0.
- R5: With `rf_we` set, the bus value is written to the selected register at the edge. Register 0 always reads as zero, and writes to it have no effect.
- R6: The ALU result is A+B for `alu_fn`=0, A−B for 1, A&B for 2 and A|B for 3 (modulo 2^32). When `alu_pass` is 1 the result is A, whatever `alu_fn` is.
- R7: `zero` is 1 exactly when the A latch holds 0.
- R8: The extender result depends on `imm_mode`. 0 gives sign-extended IR[15:0]. 1 gives sign-extended IR[15:0] shifted left by 2. 2 gives {PC[31:28], IR[25:0], 2'b00}. 3 gives the constant 4.
- R9: `mem_addr` equals MA. `mem_we` follows `st_mem`, `mem_rd` follows `drv_mem`, and `mem_stall` follows `mem_busy`.
- R10: `opcode` equals IR[31:26].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_rf | input | 1 | Register file drives the bus |
| drv_ext | input | 1 | Immediate extender drives the bus |
| drv_alu | input | 1 | ALU drives the bus |
| drv_mem | input | 1 | Memory read data drives the bus |
| cap_ir | input | 1 | Load instruction register from bus |
| cap_a | input | 1 | Load A operand latch from bus |
| cap_b | input | 1 | Load B operand latch from bus |
| cap_ma | input | 1 | Load memory address register from bus |
| rf_sel | input | 3 | Register index source select |
| rf_we | input | 1 | Write bus into selected register |
| st_mem | input | 1 | Write bus to memory at MA |
| imm_mode | input | 2 | Extender function select |
| alu_fn | input | 2 | ALU operation select |
| alu_pass | input | 1 | ALU forwards A unchanged |
| mem_rdata | input | 32 | Memory read data |
| mem_busy | input | 1 | Memory access still pending |
| opcode | output | 6 | Opcode field of IR |
| zero | output | 1 | A latch equals zero |
| mem_stall | output | 1 | Stall status for the sequencer |
| mem_addr | output | 32 | Memory address (MA) |
| mem_wdata | output | 32 | Memory write data (bus value) |
| mem_we | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |

## Verification
The properties assume that the microcode never turns on two bus drivers in the same cycle. When it does, the bus value is undefined, so the capture, register-0 and opcode properties would make no sense. The stimulus sets all controls through one task that clears every driver enable before it raises exactly one. Operand values get onto the bus only through the memory-read path or the register file, one at a time.

// File: rtl/sbus_datapath.sv
module sbus_datapath #(
  parameter int W    = 32,
  parameter int NGPR = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         drv_rf,
  input  logic         drv_ext,
  input  logic         drv_alu,
  input  logic         drv_mem,
  input  logic         cap_ir,
  input  logic         cap_a,
  input  logic         cap_b,
  input  logic         cap_ma,
  input  logic [2:0]   rf_sel,
  input  logic         rf_we,
  input  logic         st_mem,
  input  logic [1:0]   imm_mode,
  input  logic [1:0]   alu_fn,
  input  logic         alu_pass,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_busy,
  output logic [5:0]   opcode,
  output logic         zero,
  output logic         mem_stall,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         mem_we,
  output logic         mem_rd
);
  localparam int NENT   = NGPR + 1;
  localparam int IW     = $clog2(NENT);
  localparam int PC_IDX = NGPR;
  localparam int LNK    = NGPR - 1;

  logic [W-1:0] ir_q, a_q, b_q, ma_q;
  logic [W-1:0] rf [NENT];
  logic [W-1:0] bus, rf_rd, ext_val, alu_val;
  logic [IW-1:0] rf_idx;

  always_comb begin
    case (rf_sel)
      3'd0:    rf_idx = IW'(ir_q[25:21]);
      3'd1:    rf_idx = IW'(ir_q[20:16]);
      3'd2:    rf_idx = IW'(ir_q[15:11]);
      3'd3:    rf_idx = IW'(LNK);
      3'd4:    rf_idx = IW'(PC_IDX);
      default: rf_idx = '0;
    endcase
  end

  assign rf_rd = (rf_idx == '0) ? '0 : rf[rf_idx];

  always_comb begin
    case (imm_mode)
      2'd0:    ext_val = {{(W-16){ir_q[15]}}, ir_q[15:0]};
      2'd1:    ext_val = {{(W-18){ir_q[15]}}, ir_q[15:0], 2'b00};
      2'd2:    ext_val = {rf[PC_IDX][W-1:W-4], ir_q[25:0], 2'b00};
      default: ext_val = W'(4);
    endcase
  end

  always_comb begin
    if (alu_pass) alu_val = a_q;
    else begin
      case (alu_fn)
        2'd0:    alu_val = a_q + b_q;
        2'd1:    alu_val = a_q - b_q;
        2'd2:    alu_val = a_q & b_q;
        default: alu_val = a_q | b_q;
      endcase
    end
  end

  assign bus = ({W{drv_rf}}  & rf_rd)   |
               ({W{drv_ext}} & ext_val) |
               ({W{drv_alu}} & alu_val) |
               ({W{drv_mem}} & mem_rdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
      ma_q <= '0;
    end else begin
      if (cap_ir) ir_q <= bus;
      if (cap_a)  a_q  <= bus;
      if (cap_b)  b_q  <= bus;
      if (cap_ma) ma_q <= bus;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) rf[i] <= '0;
    end else if (rf_we && rf_idx != '0) begin
      rf[rf_idx] <= bus;
    end
  end

  assign opcode    = ir_q[31:26];
  assign zero      = (a_q == '0);
  assign mem_stall = mem_busy;
  assign mem_addr  = ma_q;
  assign mem_wdata = bus;
  assign mem_we    = st_mem;
  assign mem_rd    = drv_mem;
endmodule

// File: rtl/sbus_datapath_chk.sv
module sbus_datapath_chk #(
  parameter int W  = 32,
  parameter int IW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          drv_rf,
  input logic          drv_ext,
  input logic          drv_alu,
  input logic          drv_mem,
  input logic          cap_a,
  input logic          cap_ir,
  input logic [W-1:0]  bus,
  input logic [W-1:0]  a_q,
  input logic [IW-1:0] rf_idx,
  input logic          zero,
  input logic [5:0]    opcode
);
  logic one_drv;
  assign one_drv = $onehot0({drv_rf, drv_ext, drv_alu, drv_mem});

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({drv_rf, drv_ext, drv_alu, drv_mem}) <= 1); // R2
  AST_A_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_a |=> a_q == $past(bus)); // R3
  AST_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_a |=> $stable(a_q)); // R3
  AST_REG0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_rf && one_drv && rf_idx == '0) |-> bus == '0); // R5
  AST_ZERO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_a && bus == '0) |=> zero); // R7
  AST_ZERO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_a && bus != '0) |=> !zero); // R7
  AST_OPCODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ir |=> opcode == $past(bus[31:26])); // R10
endmodule

bind sbus_datapath sbus_datapath_chk #(.W(W), .IW(IW)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .drv_rf(drv_rf), .drv_ext(drv_ext), .drv_alu(drv_alu), .drv_mem(drv_mem),
  .cap_a(cap_a), .cap_ir(cap_ir), .bus(bus), .a_q(a_q), .rf_idx(rf_idx),
  .zero(zero), .opcode(opcode)
);

// File: tb/sbus_datapath_tb_top.sv
module sbus_datapath_tb_top;
  logic clk = 0, rst_n = 0;
  logic drv_rf, drv_ext, drv_alu, drv_mem, cap_ir, cap_a, cap_b, cap_ma;
  logic [2:0] rf_sel;
  logic rf_we, st_mem, alu_pass, mem_busy;
  logic [1:0] imm_mode, alu_fn;
  logic [31:0] mem_rdata;
  logic [5:0] opcode;
  logic zero, mem_stall, mem_we, mem_rd;
  logic [31:0] mem_addr, mem_wdata;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  sbus_datapath dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clr();
    {drv_rf, drv_ext, drv_alu, drv_mem, cap_ir, cap_a, cap_b, cap_ma} = '0;
    {rf_we, st_mem, alu_pass, mem_busy} = '0;
    rf_sel = 0; imm_mode = 0; alu_fn = 0; mem_rdata = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1; clr();
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic mem_to(input logic [31:0] v, input int dst);
    drv_mem = 1; mem_rdata = v;
    case (dst) 0: cap_ir = 1; 1: cap_a = 1; 2: cap_b = 1; default: cap_ma = 1; endcase
    tick();
  endtask

  task automatic wr_sel(input logic [2:0] s, input logic [31:0] v);
    drv_mem = 1; mem_rdata = v; rf_sel = s; rf_we = 1; tick();
  endtask

  task automatic rd_sel(input logic [2:0] s, output logic [31:0] v);
    drv_rf = 1; rf_sel = s; settle(); v = mem_wdata; clr();
  endtask

  function automatic logic [31:0] ir_rd(input int r);
    return {16'd0, r[4:0], 11'd0};
  endfunction

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    clr();
    #22 rst_n = 1;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1 opcode", {26'd0, opcode}, 0);
    chk("R1 zero", {31'd0, zero}, 1);
    chk("R1 mem_addr", mem_addr, 0);
    rd_sel(3'd4, v); chk("R1 pc", v, 0);
    rd_sel(3'd3, v); chk("R1 link", v, 0);
    drv_alu = 1; settle(); chk("R1 a+b", mem_wdata, 0); clr();

    // R5 write all GPRs, then read back
    for (int r = 0; r < 32; r++) begin
      mem_to(ir_rd(r), 0);
      wr_sel(3'd2, 32'h5A00_0000 + r * 32'h0101_0007);
    end
    for (int r = 0; r < 32; r++) begin
      mem_to(ir_rd(r), 0);
      rd_sel(3'd2, v);
      chk("R5 readback", v, r == 0 ? 32'd0 : 32'h5A00_0000 + r * 32'h0101_0007);
    end
    // R4 index selection
    mem_to({6'd0, 5'd3, 5'd7, 5'd9, 11'd0}, 0);
    rd_sel(3'd0, v); chk("R4 rs", v, 32'h5A00_0000 + 3 * 32'h0101_0007);
    rd_sel(3'd1, v); chk("R4 rt", v, 32'h5A00_0000 + 7 * 32'h0101_0007);
    rd_sel(3'd2, v); chk("R4 rd", v, 32'h5A00_0000 + 9 * 32'h0101_0007);
    rd_sel(3'd3, v); chk("R4 link", v, 32'h5A00_0000 + 31 * 32'h0101_0007);
    for (int s = 5; s < 8; s++) begin
      rd_sel(s[2:0], v); chk("R4 spare code", v, 0);
    end
    wr_sel(3'd4, 32'hA000_1000);
    rd_sel(3'd4, v); chk("R4 pc entry", v, 32'hA000_1000);
    rd_sel(3'd3, v); chk("R4 link kept", v, 32'h5A00_0000 + 31 * 32'h0101_0007);
    wr_sel(3'd6, 32'hFFFF_FFFF);
    rd_sel(3'd6, v); chk("R5 reg0 write ignored", v, 0);

    // R10 opcode sweep
    for (int op = 0; op < 64; op++) begin
      mem_to({op[5:0], 26'h155_5555}, 0);
      chk("R10 opcode", {26'd0, opcode}, op);
    end

    // R8 extender
    for (int k = 0; k < 6; k++) begin
      logic [15:0] im;
      im = (k == 0) ? 16'h8001 : (k == 1) ? 16'h7FFF : (k == 2) ? 16'h0000 :
           (k == 3) ? 16'hFFFF : (k == 4) ? 16'h4000 : 16'hC000;
      mem_to({16'h0000, im}, 0);
      drv_ext = 1; imm_mode = 0; settle();
      chk("R8 sext", mem_wdata, {{16{im[15]}}, im}); clr();
      drv_ext = 1; imm_mode = 1; settle();
      chk("R8 sext<<2", mem_wdata, {{14{im[15]}}, im, 2'b00}); clr();
    end
    mem_to({6'd2, 26'h2AB_CDEF}, 0);
    drv_ext = 1; imm_mode = 2; settle();
    chk("R8 jump target", mem_wdata, {4'hA, 26'h2AB_CDEF, 2'b00}); clr();
    drv_ext = 1; imm_mode = 3; settle();
    chk("R8 const4", mem_wdata, 32'd4); clr();

    // R6 ALU sweep, R3 capture/hold, R7 zero
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [31:0] a, b;
        a = (i == 0) ? 0 : 32'h8000_0001 * i ^ (32'h0F0F_0F0F << i);
        b = (j == 0) ? 0 : 32'h7FFF_FFFF * j ^ (32'h3333_3333 >> j);
        mem_to(a, 1);
        mem_to(b, 2);
        chk("R7 zero", {31'd0, zero}, a == 0);
        drv_alu = 1; alu_fn = 0; settle(); chk("R6 add", mem_wdata, a + b); clr();
        drv_alu = 1; alu_fn = 1; settle(); chk("R6 sub", mem_wdata, a - b); clr();
        drv_alu = 1; alu_fn = 2; settle(); chk("R6 and", mem_wdata, a & b); clr();
        drv_alu = 1; alu_fn = 3; settle(); chk("R6 or", mem_wdata, a | b); clr();
        drv_alu = 1; alu_fn = j[1:0]; alu_pass = 1; settle();
        chk("R6 pass", mem_wdata, a); clr();
      end
    end
    mem_to(32'h1111_2222, 1);
    mem_to(32'h3333_4444, 2);
    mem_to(32'h9999_0000, 3);
    drv_alu = 1; alu_pass = 1; settle(); chk("R3 A held", mem_wdata, 32'h1111_2222); clr();
    drv_alu = 1; alu_fn = 1; settle(); chk("R3 B held", mem_wdata, 32'h1111_2222 - 32'h3333_4444); clr();
    chk("R9 mem_addr", mem_addr, 32'h9999_0000);
    mem_to(32'h0, 1);
    chk("R7 zero A=0", {31'd0, zero}, 1);
    chk("R3 MA held", mem_addr, 32'h9999_0000);
    drv_alu = 1; cap_ma = 1; alu_fn = 0; tick();
    chk("R3 MA from ALU", mem_addr, 32'h3333_4444);

    // R9 memory port strobes
    mem_busy = 1; settle(); chk("R9 stall", {31'd0, mem_stall}, 1); clr();
    settle(); chk("R9 stall low", {31'd0, mem_stall}, 0);
    st_mem = 1; drv_rf = 1; rf_sel = 3'd4; settle();
    chk("R9 we", {31'd0, mem_we}, 1);
    chk("R2 wdata", mem_wdata, 32'hA000_1000); clr();
    drv_mem = 1; mem_rdata = 32'hDEAD_BEEF; settle();
    chk("R9 rd", {31'd0, mem_rd}, 1);
    chk("R2 mem onto bus", mem_wdata, 32'hDEAD_BEEF); clr();
    settle(); chk("R2 idle bus", mem_wdata, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule